// File: doc/BRIEF.md
# Segmented Resource Access Steering Unit

This block sits between a 16-bit host bus and the internal resources of a 64-bit associative memory. Each host transfer is one of four kinds: data read, data write, command read or command write. The block decides which internal resource the transfer reaches. It then drives a resource select code, a read or write enable, and a segment index that picks one 16-bit slice of a 64-bit resource. Slice 0 carries bits 15..0 and slice 3 carries bits 63..48.

Data transfers go to a selected source (for reads) and a selected destination (for writes). After reset both selections point at the comparand. Each selection can be changed by its own instruction and keeps its value until the next instruction of that kind. Command writes normally carry instructions, and command reads normally return the status word. A one-shot override instruction sends the next command transfer to a side register instead. The side registers are control, page address, segment control, address, next-free address and device select. The same override can also read back the current source and destination selections. A segment counter, with a start and end that software sets, advances after every data transfer.

Top module: `steer_unit`

## Requirements
- R1: After reset, a data read selects the comparand (`res_sel`=0) with `res_rd_en` high and passes `res_rdata` to `dout`. A data write selects the comparand with `res_wr_en` high.
- R2: Command write 0x01_0s (s in 0..3, bits 7..2 zero) sets the data source to s, where 0=comparand, 1=mask 1, 2=mask 2, 3=array. The destination does not change.
- R3: Command write 0x02_0d sets the data destination to d, using the same codes as R2. The source does not change.
- R4: With no override pending, a command write selects the instruction port (`res_sel`=4, `res_wr_en`). A command read selects status (`res_sel`=5, `res_rd_en`) and returns `res_rdata` on `dout`.
- R5: Command write 0x03_0t arms an override. The next command transfer goes to target t: 0=control (6), 1=page (7), 3=address (9), 4=next free (10), 5=device select (11). Each of these is an external resource with the matching enable.
- R6: The override applies to exactly one command transfer. Data transfers in between use the persistent routing and leave the override armed.
- R7: Override targets 6 and 7 read back the source code and destination code on `dout[1:0]`, with zeros above. Both enables stay low. Writing to these targets loads the selection.
- R8: Override target 2 reaches the local segment control word: start in bits 1..0, end in bits 3..2. A write reloads the segment counter to start. A read returns the word.
- R9: The segment counter starts at 0 with end 3. It advances after each data transfer and wraps from end to start. Command transfers leave it unchanged.
- R10: Any other command write value is ignored. It changes neither selection and arms no override.
- R11: `res_wdata` equals `din` during writes. The enables are never both high and are low when `cyc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Transfer present this cycle |
| cyc_cmd | input | 1 | 1 = command transfer, 0 = data transfer |
| cyc_wr | input | 1 | 1 = write, 0 = read |
| din | input | DW | Host write data |
| dout | output | DW | Host read data |
| res_sel | output | 4 | Selected resource code |
| res_rd_en | output | 1 | Read enable to the selected resource |
| res_wr_en | output | 1 | Write enable to the selected resource |
| res_seg | output | SEG_W | Segment index of the transfer |
| res_wdata | output | DW | Write data to the resource |
| res_rdata | input | DW | Read data from the selected resource |

## Verification
A wrong source or destination register, or a wrong override flag, appears on `res_sel` in the very next transfer of the affected kind. Data transfers and the readback targets expose these states without reading internals. A counter that has slipped appears on `res_seg` in the next data transfer. Comparing several transfers in a row shows whether the wrap point is wrong. A stuck override shows up as a second redirected command transfer one cycle after the first.

// File: rtl/steer_pkg.sv
package steer_pkg;

   typedef enum logic [3:0] {
      RS_CMP    = 4'd0,
      RS_MASK1  = 4'd1,
      RS_MASK2  = 4'd2,
      RS_ARRAY  = 4'd3,
      RS_INSTR  = 4'd4,
      RS_STATUS = 4'd5,
      RS_CTRL   = 4'd6,
      RS_PAGE   = 4'd7,
      RS_SEGCTL = 4'd8,
      RS_ADDR   = 4'd9,
      RS_NFREE  = 4'd10,
      RS_DEVSEL = 4'd11,
      RS_PSRD   = 4'd12,
      RS_PDRD   = 4'd13
   } res_e;

   localparam logic [7:0] OP_SPS = 8'h01;
   localparam logic [7:0] OP_SPD = 8'h02;
   localparam logic [7:0] OP_TCO = 8'h03;

   function automatic res_e tco_target(input logic [2:0] t);
      case (t)
         3'd0:    return RS_CTRL;
         3'd1:    return RS_PAGE;
         3'd2:    return RS_SEGCTL;
         3'd3:    return RS_ADDR;
         3'd4:    return RS_NFREE;
         3'd5:    return RS_DEVSEL;
         3'd6:    return RS_PSRD;
         default: return RS_PDRD;
      endcase
   endfunction

   function automatic logic is_local(input res_e r);
      return (r == RS_SEGCTL) || (r == RS_PSRD) || (r == RS_PDRD);
   endfunction

endpackage

// File: rtl/steer_decode.sv
module steer_decode #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] word,
   output logic          hit_sps,
   output logic          hit_spd,
   output logic          hit_tco,
   output logic [2:0]    arg
);
   import steer_pkg::*;

   logic upper_zero;

   generate
      if (DW > 16) begin : g_wide
         assign upper_zero = ~|word[DW-1:16];
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      hit_sps = upper_zero && (word[15:8] == OP_SPS) && (word[7:2] == 6'd0);
      hit_spd = upper_zero && (word[15:8] == OP_SPD) && (word[7:2] == 6'd0);
      hit_tco = upper_zero && (word[15:8] == OP_TCO) && (word[7:3] == 5'd0);
      arg     = word[2:0];
   end

endmodule

// File: rtl/steer_segctr.sv
module steer_segctr #(
   parameter int SEGS = 4,
   localparam int SEG_W = $clog2(SEGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEG_W-1:0] load_start,
   input  logic [SEG_W-1:0] load_end,
   input  logic             step,
   output logic [SEG_W-1:0] cnt,
   output logic [SEG_W-1:0] seg_start,
   output logic [SEG_W-1:0] seg_end
);
   localparam logic [SEG_W-1:0] LAST = SEG_W'(SEGS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         seg_start <= '0;
         seg_end   <= LAST;
      end else if (load) begin
         cnt       <= load_start;
         seg_start <= load_start;
         seg_end   <= load_end;
      end else if (step) begin
         if (cnt == seg_end) cnt <= seg_start;
         else                cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/steer_route.sv
module steer_route #(
   parameter int DW = 16,
   parameter int SEGS = 4,
   localparam int SEG_W = $clog2(SEGS)
) (
   input  logic                 cyc_valid,
   input  logic                 cyc_cmd,
   input  logic                 cyc_wr,
   input  logic                 ovr_on,
   input  steer_pkg::res_e      ovr_tgt,
   input  logic [1:0]           src,
   input  logic [1:0]           dst,
   input  logic [SEG_W-1:0]     seg_start,
   input  logic [SEG_W-1:0]     seg_end,
   input  logic [DW-1:0]        res_rdata,
   output steer_pkg::res_e      sel,
   output logic                 rd_en,
   output logic                 wr_en,
   output logic [DW-1:0]        rdata_out
);
   import steer_pkg::*;

   logic          local_hit;
   logic [DW-1:0] local_val;

   always_comb begin
      sel = RS_CMP;
      if (cyc_valid) begin
         if (!cyc_cmd)    sel = cyc_wr ? res_e'({2'b00, dst}) : res_e'({2'b00, src});
         else if (ovr_on) sel = ovr_tgt;
         else             sel = cyc_wr ? RS_INSTR : RS_STATUS;
      end
   end

   always_comb begin
      local_hit = cyc_valid && is_local(sel);
      rd_en     = cyc_valid && !cyc_wr && !local_hit;
      wr_en     = cyc_valid &&  cyc_wr && !local_hit;
   end

   always_comb begin
      local_val = '0;
      case (sel)
         RS_PSRD:   local_val[1:0] = src;
         RS_PDRD:   local_val[1:0] = dst;
         RS_SEGCTL: local_val[2*SEG_W-1:0] = {seg_end, seg_start};
         default:   local_val = '0;
      endcase
      if (!cyc_valid || cyc_wr) rdata_out = '0;
      else if (local_hit)       rdata_out = local_val;
      else                      rdata_out = res_rdata;
   end

endmodule

// File: rtl/steer_unit.sv
module steer_unit #(
   parameter int DW = 16,
   parameter int SEGS = 4,
   localparam int SEG_W = $clog2(SEGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_valid,
   input  logic             cyc_cmd,
   input  logic             cyc_wr,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dout,
   output logic [3:0]       res_sel,
   output logic             res_rd_en,
   output logic             res_wr_en,
   output logic [SEG_W-1:0] res_seg,
   output logic [DW-1:0]    res_wdata,
   input  logic [DW-1:0]    res_rdata
);
   import steer_pkg::*;

   initial begin
      if (DW < 16) $error("steer_unit: DW must be at least 16");
      if (SEGS < 2 || (SEGS & (SEGS - 1)) != 0) $error("steer_unit: SEGS must be a power of two >= 2");
      if (2 * SEG_W > DW) $error("steer_unit: segment control word does not fit DW");
   end

   logic [1:0]       src_q, dst_q;
   logic             ovr_q;
   res_e             ovr_tgt_q;
   logic             hit_sps, hit_spd, hit_tco;
   logic [2:0]       arg;
   res_e             sel;
   logic [SEG_W-1:0] seg_start, seg_end;
   logic             seg_load, seg_step;
   logic             cmd_wr, cmd_any;

   steer_decode #(.DW(DW)) u_dec (
      .word    (din),
      .hit_sps (hit_sps),
      .hit_spd (hit_spd),
      .hit_tco (hit_tco),
      .arg     (arg)
   );

   steer_route #(.DW(DW), .SEGS(SEGS)) u_route (
      .cyc_valid (cyc_valid),
      .cyc_cmd   (cyc_cmd),
      .cyc_wr    (cyc_wr),
      .ovr_on    (ovr_q),
      .ovr_tgt   (ovr_tgt_q),
      .src       (src_q),
      .dst       (dst_q),
      .seg_start (seg_start),
      .seg_end   (seg_end),
      .res_rdata (res_rdata),
      .sel       (sel),
      .rd_en     (res_rd_en),
      .wr_en     (res_wr_en),
      .rdata_out (dout)
   );

   always_comb begin
      cmd_any  = cyc_valid && cyc_cmd;
      cmd_wr   = cmd_any && cyc_wr;
      seg_load = cmd_wr && ovr_q && (ovr_tgt_q == RS_SEGCTL);
      seg_step = cyc_valid && !cyc_cmd;
   end

   steer_segctr #(.SEGS(SEGS)) u_seg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (seg_load),
      .load_start (din[SEG_W-1:0]),
      .load_end   (din[2*SEG_W-1:SEG_W]),
      .step       (seg_step),
      .cnt        (res_seg),
      .seg_start  (seg_start),
      .seg_end    (seg_end)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q     <= 2'd0;
         dst_q     <= 2'd0;
         ovr_q     <= 1'b0;
         ovr_tgt_q <= RS_CTRL;
      end else if (cmd_any) begin
         if (ovr_q) begin
            ovr_q <= 1'b0;
            if (cyc_wr && ovr_tgt_q == RS_PSRD) src_q <= din[1:0];
            if (cyc_wr && ovr_tgt_q == RS_PDRD) dst_q <= din[1:0];
         end else if (cyc_wr) begin
            if (hit_sps) src_q <= arg[1:0];
            if (hit_spd) dst_q <= arg[1:0];
            if (hit_tco) begin
               ovr_q     <= 1'b1;
               ovr_tgt_q <= tco_target(arg);
            end
         end
      end
   end

   assign res_sel   = sel;
   assign res_wdata = (cyc_valid && cyc_wr) ? din : '0;

endmodule

// File: rtl/steer_unit_chk.sv
module steer_unit_chk #(
   parameter int SEG_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cyc_valid,
   input logic             cyc_cmd,
   input logic             cyc_wr,
   input logic [3:0]       res_sel,
   input logic             res_rd_en,
   input logic             res_wr_en,
   input logic [SEG_W-1:0] res_seg
);

   assert_enable_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_rd_en && res_wr_en));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_valid |-> (!res_rd_en && !res_wr_en));

   assert_data_persist_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && !cyc_cmd) |-> (res_sel < 4'd4));

   assert_cmd_instr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_cmd && cyc_wr && res_sel == 4'd4) |-> res_wr_en);

   assert_ovr_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_cmd && res_sel >= 4'd6) |=>
      (!(cyc_valid && cyc_cmd) || res_sel == 4'd4 || res_sel == 4'd5));

   assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_valid || (cyc_cmd && res_sel != 4'd8)) |=> $stable(res_seg));

endmodule

bind steer_unit steer_unit_chk #(.SEG_W(SEG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cyc_valid (cyc_valid),
   .cyc_cmd   (cyc_cmd),
   .cyc_wr    (cyc_wr),
   .res_sel   (res_sel),
   .res_rd_en (res_rd_en),
   .res_wr_en (res_wr_en),
   .res_seg   (res_seg)
);

// File: tb/tb_steer_unit.sv
`timescale 1ns/1ps
module tb_steer_unit;
   localparam int CLK_P = 10;
   localparam logic [15:0] RDV = 16'hC3E1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_valid = 1'b0, cyc_cmd = 1'b0, cyc_wr = 1'b0;
   logic [15:0] din = '0;
   logic [15:0] dout, res_wdata;
   logic [15:0] res_rdata = RDV;
   logic [3:0]  res_sel;
   logic        res_rd_en, res_wr_en;
   logic [1:0]  res_seg;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [3:0]  s_sel;
   logic        s_rd, s_wr;
   logic [1:0]  s_seg;
   logic [15:0] s_dout, s_wdata;

   steer_unit dut (
      .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_cmd(cyc_cmd),
      .cyc_wr(cyc_wr), .din(din), .dout(dout), .res_sel(res_sel),
      .res_rd_en(res_rd_en), .res_wr_en(res_wr_en), .res_seg(res_seg),
      .res_wdata(res_wdata), .res_rdata(res_rdata)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cyc_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic xfer(input bit cmd, input bit wr, input logic [15:0] d);
      @(negedge clk);
      cyc_valid = 1'b1; cyc_cmd = cmd; cyc_wr = wr; din = d;
      #(CLK_P/4);
      s_sel = res_sel; s_rd = res_rd_en; s_wr = res_wr_en;
      s_seg = res_seg; s_dout = dout; s_wdata = res_wdata;
      @(posedge clk);
      #1;
      cyc_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R11 idle rd_en", {15'd0, res_rd_en}, 16'd0);
      chk("R11 idle wr_en", {15'd0, res_wr_en}, 16'd0);
      xfer(0, 0, 16'h0);
      chk("R1 rd sel", {12'd0, s_sel}, 16'd0);
      chk("R1 rd en", {15'd0, s_rd}, 16'd1);
      chk("R1 rd data", s_dout, RDV);
      chk("R9 first seg", {14'd0, s_seg}, 16'd0);
      xfer(0, 1, 16'h5A17);
      chk("R1 wr sel", {12'd0, s_sel}, 16'd0);
      chk("R1 wr en", {15'd0, s_wr}, 16'd1);
      chk("R11 wdata", s_wdata, 16'h5A17);
   endtask

   task automatic t_sps();
      do_reset();
      xfer(1, 1, 16'h0102);
      xfer(0, 0, 16'h0);
      chk("R2 src mask2", {12'd0, s_sel}, 16'd2);
      xfer(0, 1, 16'h0);
      chk("R2 dst kept", {12'd0, s_sel}, 16'd0);
   endtask

   task automatic t_spd();
      do_reset();
      xfer(1, 1, 16'h0203);
      xfer(0, 1, 16'h0);
      chk("R3 dst array", {12'd0, s_sel}, 16'd3);
      xfer(0, 0, 16'h0);
      chk("R3 src kept", {12'd0, s_sel}, 16'd0);
   endtask

   task automatic t_cmd_default();
      do_reset();
      xfer(1, 1, 16'h1234);
      chk("R4 cmd wr sel", {12'd0, s_sel}, 16'd4);
      chk("R4 cmd wr en", {15'd0, s_wr}, 16'd1);
      xfer(1, 0, 16'h0);
      chk("R4 cmd rd sel", {12'd0, s_sel}, 16'd5);
      chk("R4 cmd rd data", s_dout, RDV);
   endtask

   task automatic t_tco();
      logic [2:0] tg [5] = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd5};
      logic [3:0] cd [5] = '{4'd6, 4'd7, 4'd9, 4'd10, 4'd11};
      do_reset();
      for (int i = 0; i < 5; i++) begin
         xfer(1, 1, {13'h0060, tg[i]});
         xfer(1, 0, 16'h0);
         chk("R5 ovr sel", {12'd0, s_sel}, {12'd0, cd[i]});
         chk("R5 ovr rd en", {15'd0, s_rd}, 16'd1);
         xfer(1, 0, 16'h0);
         chk("R6 back to status", {12'd0, s_sel}, 16'd5);
      end
   endtask

   task automatic t_ovr_data();
      do_reset();
      xfer(1, 1, 16'h0300);
      xfer(0, 0, 16'h0);
      chk("R6 data keeps route", {12'd0, s_sel}, 16'd0);
      xfer(1, 1, 16'hBEEF);
      chk("R6 ovr still armed", {12'd0, s_sel}, 16'd6);
      chk("R11 ovr wdata", s_wdata, 16'hBEEF);
      xfer(1, 1, 16'h1111);
      chk("R6 ovr consumed", {12'd0, s_sel}, 16'd4);
   endtask

   task automatic t_readback();
      do_reset();
      xfer(1, 1, 16'h0101);
      xfer(1, 1, 16'h0202);
      xfer(1, 1, 16'h0306);
      xfer(1, 0, 16'h0);
      chk("R7 src readback", s_dout, 16'd1);
      chk("R7 no ext enable", {15'd0, s_rd}, 16'd0);
      xfer(1, 1, 16'h0307);
      xfer(1, 0, 16'h0);
      chk("R7 dst readback", s_dout, 16'd2);
      xfer(1, 1, 16'h0306);
      xfer(1, 1, 16'h0003);
      xfer(0, 0, 16'h0);
      chk("R7 src loaded by write", {12'd0, s_sel}, 16'd3);
   endtask

   task automatic t_segments();
      logic [1:0] exp_d [5] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
      logic [1:0] exp_p [4] = '{2'd1, 2'd2, 2'd1, 2'd2};
      do_reset();
      for (int i = 0; i < 5; i++) begin
         xfer(0, i[0], 16'h0);
         chk("R9 default seq", {14'd0, s_seg}, {14'd0, exp_d[i]});
         if (i == 1) begin
            xfer(1, 0, 16'h0);
            chk("R9 cmd no step", {14'd0, s_seg}, 16'd2);
         end
      end
      xfer(1, 1, 16'h0302);
      xfer(1, 1, 16'h0009);
      for (int i = 0; i < 4; i++) begin
         xfer(0, 0, 16'h0);
         chk("R8 R9 prog seq", {14'd0, s_seg}, {14'd0, exp_p[i]});
      end
      xfer(1, 1, 16'h0302);
      xfer(1, 0, 16'h0);
      chk("R8 segctl readback", s_dout, 16'h0009);
   endtask

   task automatic t_unknown();
      do_reset();
      xfer(1, 1, 16'h0101);
      xfer(1, 1, 16'h0104);
      xfer(1, 1, 16'h0400);
      xfer(1, 1, 16'h0308 | 16'h0010);
      xfer(0, 0, 16'h0);
      chk("R10 src unchanged", {12'd0, s_sel}, 16'd1);
      xfer(0, 1, 16'h0);
      chk("R10 dst unchanged", {12'd0, s_sel}, 16'd0);
      xfer(1, 0, 16'h0);
      chk("R10 no override", {12'd0, s_sel}, 16'd5);
   endtask

   initial begin
      #(CLK_P * 50000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_sps();
      t_spd();
      t_cmd_default();
      t_tco();
      t_ovr_data();
      t_readback();
      t_segments();
      t_unknown();
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule